// File: doc/BRIEF.md
# OFDM Subcarrier Reorder and Cyclic Prefix Framer

This block sits on both sides of an external 64-point inverse transform in an OFDM transmitter. On the frequency side it gathers one symbol of 64 complex samples and presents them to the transform with the two 32-sample halves swapped, so that input samples 32..63 come out first and input samples 0..31 follow. On the time side it takes the 64 time-domain samples the transform returns. It emits each symbol as an 80-sample burst. The burst opens with a 16-sample cyclic prefix copied from the symbol's tail, and the whole symbol follows.

All four streams use valid/ready handshakes and carry complex samples with 16-bit I and 16-bit Q. The frequency side holds one symbol buffer. It alternates between collecting and emitting, and it is cleared to zero at reset. The time side holds two symbol buffers used in ping-pong fashion, so one symbol can be written while the previous burst drains. Each outgoing stream marks the final sample of a symbol with a last flag.

Top module: `ofdm_cp_framer`

## Requirements
- R1: After reset, both input streams are ready (`fin_ready`, `tin_ready` high) and neither output stream is valid (`fout_valid`, `tout_valid` low).
- R2: The k-th reordered sample of a symbol (k = 0..63) equals input sample (k+32) mod 64 of the same symbol, for both I and Q.
- R3: `fout_last` is high on the 64th reordered sample of each symbol and low on the other 63.
- R4: While the frequency side is presenting reordered samples (`fout_valid` high), it accepts no new input (`fin_ready` low).
- R5: The j-th sample of each 80-sample output burst (j = 0..79) equals time sample 48+j for j < 16 and time sample j-16 for j >= 16 of the corresponding 64-sample symbol.
- R6: `tout_last` is high on the 80th sample of each output burst and low on the other 79.
- R7: The time side accepts a second symbol while the first burst is still waiting to drain. `tin_ready` drops only once two complete symbols are buffered and not yet fully emitted.
- R8: While an output is valid and its ready is low, that output stays valid and its data and last flag stay unchanged. No sample is lost or repeated on either side.
- R9: Each 64-sample input symbol produces exactly one 64-sample reordered symbol and exactly one 80-sample output burst, in arrival order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fin_valid | input | 1 | Frequency-domain input sample valid |
| fin_ready | output | 1 | Frequency-domain input can be accepted |
| fin_i | input | 16 | Input sample, in-phase part |
| fin_q | input | 16 | Input sample, quadrature part |
| fout_valid | output | 1 | Reordered sample to the transform valid |
| fout_ready | input | 1 | Transform accepts reordered sample |
| fout_i | output | 16 | Reordered sample, in-phase part |
| fout_q | output | 16 | Reordered sample, quadrature part |
| fout_last | output | 1 | Final reordered sample of a symbol |
| tin_valid | input | 1 | Time-domain sample from the transform valid |
| tin_ready | output | 1 | Time-domain sample can be accepted |
| tin_i | input | 16 | Time-domain sample, in-phase part |
| tin_q | input | 16 | Time-domain sample, quadrature part |
| tout_valid | output | 1 | Framed output sample valid |
| tout_ready | input | 1 | Downstream accepts framed sample |
| tout_i | output | 16 | Framed sample, in-phase part |
| tout_q | output | 16 | Framed sample, quadrature part |
| tout_last | output | 1 | Final sample of an 80-sample burst |

## Verification
The assertions watch three things on every cycle. Both outputs must hold valid, data and last flag steady under backpressure. Each last flag must line up with a position counter kept apart from the datapath, so it fires exactly once every 64 and every 80 handshakes. The bench models the transform as an identity and chains the two sides through it. Only its scenarios can show the data content: the half swap, the prefix taken from the symbol tail, that the symbol order is kept, and that a second symbol is taken in while the first burst is held. Those scenarios mix input gaps with output stalls.

// File: rtl/ofdm_cp_framer.sv
module ofdm_cp_framer #(
  parameter int DW = 16,
  parameter int N  = 64,
  parameter int CP = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fin_valid,
  output logic          fin_ready,
  input  logic [DW-1:0] fin_i,
  input  logic [DW-1:0] fin_q,
  output logic          fout_valid,
  input  logic          fout_ready,
  output logic [DW-1:0] fout_i,
  output logic [DW-1:0] fout_q,
  output logic          fout_last,
  input  logic          tin_valid,
  output logic          tin_ready,
  input  logic [DW-1:0] tin_i,
  input  logic [DW-1:0] tin_q,
  output logic          tout_valid,
  input  logic          tout_ready,
  output logic [DW-1:0] tout_i,
  output logic [DW-1:0] tout_q,
  output logic          tout_last
);
  localparam int AW = $clog2(N);
  localparam int OL = N + CP;
  localparam int OW = $clog2(OL);
  localparam logic [AW-1:0] LAST_F = AW'(N - 1);
  localparam logic [OW-1:0] LAST_T = OW'(OL - 1);
  localparam logic [OW-1:0] CPW    = OW'(CP);
  localparam logic [OW-1:0] TAIL   = OW'(N - CP);
  localparam logic [AW-1:0] SWAP   = AW'(N / 2);

  // frequency side: one buffer, collect then emit with halves swapped
  logic [2*DW-1:0] fbuf [N];
  logic [AW-1:0]   fcnt;
  logic            femit;
  logic [AW-1:0]   frd;

  assign fin_ready  = !femit;
  assign fout_valid = femit;
  assign frd        = fcnt ^ SWAP;
  assign {fout_i, fout_q} = fbuf[frd];
  assign fout_last  = femit && (fcnt == LAST_F);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fcnt  <= '0;
      femit <= 1'b0;
      for (int k = 0; k < N; k++) fbuf[k] <= '0;
    end else if (!femit && fin_valid) begin
      fbuf[fcnt] <= {fin_i, fin_q};
      fcnt       <= fcnt + 1'b1;
      if (fcnt == LAST_F) femit <= 1'b1;
    end else if (femit && fout_ready) begin
      fcnt <= fcnt + 1'b1;
      if (fcnt == LAST_F) femit <= 1'b0;
    end
  end

  // time side: ping-pong buffers, burst = tail prefix then full symbol
  logic [2*DW-1:0] tbuf [2][N];
  logic [1:0]      full;
  logic            wbank, rbank;
  logic [AW-1:0]   wcnt;
  logic [OW-1:0]   rcnt;
  logic [OW-1:0]   rsum;

  assign tin_ready  = !full[wbank];
  assign tout_valid = full[rbank];
  assign rsum       = (rcnt < CPW) ? rcnt + TAIL : rcnt - CPW;
  assign {tout_i, tout_q} = tbuf[rbank][rsum[AW-1:0]];
  assign tout_last  = full[rbank] && (rcnt == LAST_T);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full  <= '0;
      wbank <= 1'b0;
      rbank <= 1'b0;
      wcnt  <= '0;
      rcnt  <= '0;
    end else begin
      if (tin_valid && tin_ready) begin
        tbuf[wbank][wcnt] <= {tin_i, tin_q};
        wcnt <= wcnt + 1'b1;
        if (wcnt == LAST_F) begin
          full[wbank] <= 1'b1;
          wbank       <= !wbank;
        end
      end
      if (tout_valid && tout_ready) begin
        if (rcnt == LAST_T) begin
          rcnt        <= '0;
          full[rbank] <= 1'b0;
          rbank       <= !rbank;
        end else begin
          rcnt <= rcnt + 1'b1;
        end
      end
    end
  end

  // independent position counters for the last-flag checks
  logic [AW-1:0] fpos;
  logic [OW-1:0] tpos;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fpos <= '0;
      tpos <= '0;
    end else begin
      if (fout_valid && fout_ready) fpos <= fpos + 1'b1;
      if (tout_valid && tout_ready) tpos <= (tpos == LAST_T) ? '0 : tpos + 1'b1;
    end
  end

  a_r3_last_every_64: assert property (@(posedge clk) disable iff (!rst_n)
    fout_valid |-> (fout_last == (fpos == LAST_F)));
  a_r6_last_every_80: assert property (@(posedge clk) disable iff (!rst_n)
    tout_valid |-> (tout_last == (tpos == LAST_T)));
  a_r8_freq_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (fout_valid && !fout_ready) |=> (fout_valid && $stable({fout_i, fout_q, fout_last})));
  a_r8_time_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (tout_valid && !tout_ready) |=> (tout_valid && $stable({tout_i, tout_q, tout_last})));
  a_r1_idle_after_reset: assert property (@(posedge clk)
    $rose(rst_n) |-> (fin_ready && tin_ready && !fout_valid && !tout_valid));
endmodule

// File: tb/ofdm_cp_framer_bench.sv
`timescale 1ns/1ps
module ofdm_cp_framer_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = !clk;

  logic        fin_valid = 1'b0, fin_ready;
  logic [15:0] fin_i = '0, fin_q = '0;
  logic        fout_valid, fout_last, tin_ready;
  logic [15:0] fout_i, fout_q;
  logic        tout_valid, tout_last, tout_ready = 1'b0;
  logic [15:0] tout_i, tout_q;

  // transform modelled as identity: reordered stream feeds time side directly
  ofdm_cp_framer u_ofdm_cp_framer (
    .clk(clk), .rst_n(rst_n),
    .fin_valid(fin_valid), .fin_ready(fin_ready), .fin_i(fin_i), .fin_q(fin_q),
    .fout_valid(fout_valid), .fout_ready(tin_ready), .fout_i(fout_i), .fout_q(fout_q),
    .fout_last(fout_last),
    .tin_valid(fout_valid), .tin_ready(tin_ready), .tin_i(fout_i), .tin_q(fout_q),
    .tout_valid(tout_valid), .tout_ready(tout_ready), .tout_i(tout_i), .tout_q(tout_q),
    .tout_last(tout_last));

  int total = 0, bad = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] gen(input logic [15:0] base, input int n);
    return {base + 16'(n), (base ^ 16'h5a5a) + 16'(n * 3)};
  endfunction

  // {base[27:12], input gap mask[11:8], output stall mask[7:4], symbols[3:0]}
  localparam logic [27:0] VEC [6] = '{
    {16'h0000, 4'h0, 4'h0, 4'd1},
    {16'h1234, 4'h0, 4'h0, 4'd3},
    {16'h8000, 4'h5, 4'h0, 4'd2},
    {16'hfff0, 4'h0, 4'h6, 4'd2},
    {16'h4321, 4'h9, 4'he, 4'd3},
    {16'h0abc, 4'h1, 4'h7, 4'd1}
  };

  task automatic run(input logic [15:0] base, input logic [3:0] imask,
                     input logic [3:0] omask, input int nsym, input int hold);
    int fed = 0, fo = 0, to = 0, cyc = 0;
    bit fheld = 0, theld = 0;
    logic [32:0] fsave = '0, tsave = '0;
    while (to < nsym * 80) begin
      @(negedge clk);
      fin_valid = (fed < nsym * 64) && !imask[cyc % 4];
      {fin_i, fin_q} = gen(base, fed);
      tout_ready = (cyc >= hold) && !omask[cyc % 4];
      #1;
      if (fheld) chk(fout_valid && {fout_i, fout_q, fout_last} == fsave, "R8 freq hold",
                     {fout_i, fout_q}, fsave[32:1]);
      if (theld) chk(tout_valid && {tout_i, tout_q, tout_last} == tsave, "R8 time hold",
                     {tout_i, tout_q}, tsave[32:1]);
      fheld = fout_valid && !tin_ready;
      theld = tout_valid && !tout_ready;
      fsave = {fout_i, fout_q, fout_last};
      tsave = {tout_i, tout_q, tout_last};
      if (hold > 0 && cyc == hold - 1)
        chk(!tin_ready && fout_valid && tout_valid && fed == nsym * 64, "R7 two banks held",
            {29'd0, tin_ready, fout_valid, tout_valid}, 32'h3);
      if (fout_valid) chk(!fin_ready, "R4 no input while emitting", 32'(fin_ready), 32'h0);
      if (fin_valid && fin_ready) fed++;
      if (fout_valid && tin_ready) begin
        int s = fo / 64, b = fo % 64;
        logic [31:0] e = gen(base, s * 64 + (b + 32) % 64);
        chk({fout_i, fout_q} == e, "R2 reorder", {fout_i, fout_q}, e);
        chk(fout_last == (b == 63), "R3 freq last", 32'(fout_last), 32'(b == 63));
        fo++;
      end
      if (tout_valid && tout_ready) begin
        int s = to / 80, j = to % 80;
        int tb = (j < 16) ? 48 + j : j - 16;
        logic [31:0] e = gen(base, s * 64 + (tb + 32) % 64);
        chk({tout_i, tout_q} == e, "R5 R9 prefix and order", {tout_i, tout_q}, e);
        chk(tout_last == (j == 79), "R6 burst last", 32'(tout_last), 32'(j == 79));
        to++;
      end
      cyc++;
      if (cyc > 20000) begin
        chk(1'b0, "R9 watchdog expired", 32'(to), 32'(nsym * 80));
        break;
      end
    end
    chk(fo == nsym * 64, "R9 reordered count", 32'(fo), 32'(nsym * 64));
    @(negedge clk);
    fin_valid = 1'b0;
    tout_ready = 1'b0;
    #1;
    chk(!tout_valid && !fout_valid, "R9 no extra output", {30'd0, tout_valid, fout_valid}, 32'h0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(fin_ready && tin_ready && !fout_valid && !tout_valid, "R1 reset state",
        {28'd0, fin_ready, tin_ready, fout_valid, tout_valid}, 32'hc);
    foreach (VEC[v]) run(VEC[v][27:12], VEC[v][11:8], VEC[v][7:4], int'(VEC[v][3:0]), 0);
    run(16'h7777, 4'h0, 4'h0, 3, 400);
    run(16'h0101, 4'h2, 4'hb, 3, 450);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule